// File: doc/BRIEF.md
# Endpoint Packet FIFO with Sticky Interrupt Status

A byte FIFO for a single USB-style endpoint that works on whole packets. On the write side a packet is built byte by byte and then either committed or discarded. Discarding returns the write pointer to the start of the packet, for example after a CRC failure detected elsewhere. On the read side a packet that failed in transmission can be retried by returning the read pointer to the packet start, and an acknowledge releases its bytes for reuse. Reads only see committed bytes.

A live status word reports the fill level and the conditions full, empty, error, high alarm and low alarm. A 32-bit sticky interrupt status register latches the rising edge of each of those conditions, plus end-of-frame and end-of-transfer event pulses. Software clears bits by writing ones. A mask register selects which latched bits drive the single interrupt request. Because pointers roll back on discard and retry, a full or empty state can last only one cycle. The sticky bit then records a state that the live status no longer shows.

Top module: `pkt_fifo_ep`

## Requirements
- R1: After reset the interrupt status reads 0, the mask is 0, `irq_o` is 0, `level_o` is 0, and `fsr_o` shows only empty (bit 0), with the low threshold at 0.
- R2: Committed bytes are read in write order on `rd_data_o`. `level_o` equals the bytes written (not discarded) minus the bytes read (not rewound).
- R3: Space is DEPTH minus the bytes between the acknowledged read mark and the write pointer. With no space, full (`fsr_o` bit 1) is set. A write is then dropped and sets the overflow flag (bit 5) and the error bit (bit 2).
- R4: A read with no committed unread byte is ignored, leaves `level_o` unchanged and sets the underflow flag (bit 6) and the error bit.
- R5: `pkt_discard_i` returns the write pointer to the last commit point. A write in the same cycle is dropped, and so is a commit in the same cycle.
- R6: `pkt_commit_i` moves the commit point to the write pointer, counting a write made in the same cycle. Only committed bytes can be read.
- R7: `rd_retry_i` returns the read pointer to the acknowledged mark and drops a read in the same cycle. `rd_ack_i` moves the mark to the read pointer, counting a read made in the same cycle.
- R8: The overflow and underflow flags are sticky until `fsr_clr_i` is asserted. A new error in the same cycle as the clear wins.
- R9: The high alarm (`fsr_o` bit 3) is level greater than `hi_thr_i`. The low alarm (`fsr_o` bit 4) is level less than `lo_thr_i`. Both are live.
- R10: Interrupt status bit 8 = full, bit 7 = empty, bit 6 = error, bit 5 = high, bit 4 = low. Each is set one cycle after its condition rises. Bits 31..9, 3 and 1 read 0.
- R11: A write to the interrupt status clears each bit written as 1 and leaves bits written as 0. A bit set by an event in the same cycle stays set.
- R12: `eof_i` sets bit 0 and `eot_i` sets bit 2 at the next clock edge.
- R13: `irq_o` is high exactly when some interrupt status bit and the same mask bit are both 1. The mask is written from `imr_wdata_i`, keeping only the defined bits.
- R14: A full state ended by a discard, or an empty state ended by a retry, still leaves the matching interrupt status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one byte |
| wr_data_i | input | DW | Byte to write |
| pkt_commit_i | input | 1 | Commit the packet being written |
| pkt_discard_i | input | 1 | Discard the packet being written |
| rd_en_i | input | 1 | Read one byte |
| rd_data_o | output | DW | Byte at the read pointer |
| rd_retry_i | input | 1 | Rewind the read pointer to the acknowledged mark |
| rd_ack_i | input | 1 | Advance the acknowledged mark |
| hi_thr_i | input | PW | High alarm threshold |
| lo_thr_i | input | PW | Low alarm threshold |
| fsr_clr_i | input | 1 | Clear the sticky overflow and underflow flags |
| fsr_o | output | 7 | Live status: 0 empty, 1 full, 2 error, 3 high, 4 low, 5 overflow, 6 underflow |
| level_o | output | PW | Bytes held, written minus read |
| eof_i | input | 1 | End-of-frame event pulse |
| eot_i | input | 1 | End-of-transfer event pulse |
| isr_wr_i | input | 1 | Write-one-to-clear strobe for the interrupt status |
| isr_wdata_i | input | 32 | Clear pattern |
| isr_o | output | 32 | Sticky interrupt status |
| imr_wr_i | input | 1 | Mask write strobe |
| imr_wdata_i | input | 32 | Mask value |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take the inputs to be known values at every clock edge. They allow any mix of pulses in one cycle, including commit with discard, read with retry, and a status clear together with a new event. The stimulus drives every input on the falling edge with defined values and lets all of them collide freely. It holds the thresholds within the range of the level count. Random traffic is mixed with directed sequences that fill the FIFO and discard, empty it and retry, and write the status register in the same cycle as events.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int ISR_W     = 32;
  localparam int ISR_LO    = 4;
  localparam int ISR_EOT   = 2;
  localparam int ISR_EOF   = 0;
  localparam int N_COND    = 5;
  localparam logic [ISR_W-1:0] ISR_WMASK = 32'h0000_01F5;

  // live status word, bit 0 first from the right
  typedef struct packed {
    logic udf;
    logic ovf;
    logic lo;
    logic hi;
    logic err;
    logic full;
    logic empty;
  } fsr_t;

  // order sets interrupt bit positions: lo at ISR_LO upward to full
  typedef struct packed {
    logic full;
    logic empty;
    logic err;
    logic hi;
    logic lo;
  } cond_t;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          commit_i,
  input  logic          discard_i,
  input  logic          rd_en_i,
  input  logic          retry_i,
  input  logic          ack_i,
  output logic [DW-1:0] rd_data_o,
  output logic [PW-1:0] level_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          udf_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wm_q, rp_q, rm_q;
  logic [PW-1:0] wp_nxt, rp_nxt, used;
  logic          wr_go, rd_go, has_data;

  assign used     = wp_q - rm_q;
  assign full_o   = (used == DEPTH_P);
  assign has_data = (rp_q != wm_q);
  assign wr_go    = wr_en_i & ~discard_i & ~full_o;
  assign rd_go    = rd_en_i & ~retry_i & has_data;
  assign ovf_o    = wr_en_i & ~discard_i & full_o;
  assign udf_o    = rd_en_i & ~retry_i & ~has_data;
  assign wp_nxt   = wp_q + PW'(wr_go);
  assign rp_nxt   = rp_q + PW'(rd_go);
  assign level_o  = wp_q - rp_q;

  always_ff @(posedge clk_i) begin
    if (wr_go) mem_q[wp_q[AW-1:0]] <= wr_data_i;
  end
  assign rd_data_o = mem_q[rp_q[AW-1:0]];

  // write side: discard beats write and commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      wm_q <= '0;
    end else if (discard_i) begin
      wp_q <= wm_q;
    end else begin
      wp_q <= wp_nxt;
      if (commit_i) wm_q <= wp_nxt;
    end
  end

  // read side: retry beats read and ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0;
      rm_q <= '0;
    end else if (retry_i) begin
      rp_q <= rm_q;
    end else begin
      rp_q <= rp_nxt;
      if (ack_i) rm_q <= rp_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= DEPTH_P) else $error("used space above depth"); // R3
  AST_DISCARD_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_i |=> (wp_q == $past(wm_q))) else $error("discard did not restore"); // R5
  AST_RETRY_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_i |=> (rp_q == $past(rm_q))) else $error("retry did not rewind"); // R7
  AST_RD_WITHIN_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(rp_q - rm_q) <= PW'(wm_q - rm_q)) else $error("read past commit"); // R6
  AST_COMMIT_WITHIN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(wm_q - rm_q) <= used) else $error("commit past write"); // R6
endmodule

// File: rtl/pkt_fifo_status.sv
module pkt_fifo_status
  import pkt_fifo_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] level_i,
  input  logic          full_i,
  input  logic          ovf_i,
  input  logic          udf_i,
  input  logic          clr_i,
  input  logic [PW-1:0] hi_thr_i,
  input  logic [PW-1:0] lo_thr_i,
  output fsr_t          fsr_o,
  output cond_t         cond_o
);
  logic ovf_q, udf_q;

  // new error wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_i | (ovf_q & ~clr_i);
      udf_q <= udf_i | (udf_q & ~clr_i);
    end
  end

  always_comb begin
    fsr_o.empty = (level_i == '0);
    fsr_o.full  = full_i;
    fsr_o.err   = ovf_q | udf_q;
    fsr_o.hi    = (level_i > hi_thr_i);
    fsr_o.lo    = (level_i < lo_thr_i);
    fsr_o.ovf   = ovf_q;
    fsr_o.udf   = udf_q;
    cond_o.full  = fsr_o.full;
    cond_o.empty = fsr_o.empty;
    cond_o.err   = fsr_o.err;
    cond_o.hi    = fsr_o.hi;
    cond_o.lo    = fsr_o.lo;
  end

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsr_o.err && !clr_i) |=> fsr_o.err) else $error("error flag dropped"); // R8
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i || udf_i) |=> fsr_o.err) else $error("error not latched"); // R8
endmodule

// File: rtl/pkt_fifo_irq.sv
module pkt_fifo_irq
  import pkt_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cond_t            cond_i,
  input  logic             eof_i,
  input  logic             eot_i,
  input  logic             isr_wr_i,
  input  logic [ISR_W-1:0] isr_wdata_i,
  input  logic             imr_wr_i,
  input  logic [ISR_W-1:0] imr_wdata_i,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o
);
  logic [ISR_W-1:0]  isr_q, imr_q, clr_v, set_v;
  logic [N_COND-1:0] prev_q, cond_v, edge_v;

  assign cond_v = cond_i;

  for (genvar i = 0; i < N_COND; i++) begin : g_edge
    assign edge_v[i] = cond_v[i] & ~prev_q[i];
    AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_v[i] && !prev_q[i]) |=> isr_q[ISR_LO+i]) else $error("edge lost"); // R10
  end

  assign set_v = {23'b0, edge_v, 1'b0, eot_i, 1'b0, eof_i};
  assign clr_v = isr_wr_i ? (isr_wdata_i & ISR_WMASK) : '0;

  // prev resets high so only post-reset rises latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      imr_q  <= '0;
      prev_q <= '1;
    end else begin
      isr_q  <= (isr_q & ~clr_v) | set_v;
      prev_q <= cond_v;
      if (imr_wr_i) imr_q <= imr_wdata_i & ISR_WMASK;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = |(isr_q & imr_q);

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> isr_q[ISR_EOF]) else $error("event lost to write"); // R11
  AST_EOT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_i |=> isr_q[ISR_EOT]) else $error("eot not latched"); // R12
  AST_ISR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_wr_i |=> ((isr_q & $past(isr_q)) == $past(isr_q))) else $error("bit lost"); // R11
endmodule

// File: rtl/pkt_fifo_ep.sv
module pkt_fifo_ep
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             pkt_commit_i,
  input  logic             pkt_discard_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             rd_retry_i,
  input  logic             rd_ack_i,
  input  logic [PW-1:0]    hi_thr_i,
  input  logic [PW-1:0]    lo_thr_i,
  input  logic             fsr_clr_i,
  output logic [6:0]       fsr_o,
  output logic [PW-1:0]    level_o,
  input  logic             eof_i,
  input  logic             eot_i,
  input  logic             isr_wr_i,
  input  logic [ISR_W-1:0] isr_wdata_i,
  output logic [ISR_W-1:0] isr_o,
  input  logic             imr_wr_i,
  input  logic [ISR_W-1:0] imr_wdata_i,
  output logic             irq_o
);
  logic  full, ovf, udf;
  fsr_t  fsr;
  cond_t cond;

  pkt_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_data_i,
    .commit_i (pkt_commit_i),
    .discard_i(pkt_discard_i),
    .rd_en_i,
    .retry_i  (rd_retry_i),
    .ack_i    (rd_ack_i),
    .rd_data_o,
    .level_o,
    .full_o   (full),
    .ovf_o    (ovf),
    .udf_o    (udf)
  );

  pkt_fifo_status #(.PW(PW)) u_status (
    .clk_i, .rst_ni,
    .level_i (level_o),
    .full_i  (full),
    .ovf_i   (ovf),
    .udf_i   (udf),
    .clr_i   (fsr_clr_i),
    .hi_thr_i, .lo_thr_i,
    .fsr_o   (fsr),
    .cond_o  (cond)
  );

  pkt_fifo_irq u_irq (
    .clk_i, .rst_ni,
    .cond_i (cond),
    .eof_i, .eot_i,
    .isr_wr_i, .isr_wdata_i,
    .imr_wr_i, .imr_wdata_i,
    .isr_o, .irq_o
  );

  assign fsr_o = fsr;
endmodule

// File: tb/pkt_fifo_ep_bench.sv
module pkt_fifo_ep_bench;
  localparam int D  = 16;
  localparam int PW = 5;
  localparam logic [31:0] WM = 32'h0000_01F5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic wr_en = 0, commit = 0, discard = 0, rd_en = 0, retry = 0, ack = 0;
  logic fclr = 0, eof = 0, eot = 0, isr_wr = 0, imr_wr = 0;
  logic [7:0] wd = 0;
  logic [PW-1:0] hi_thr = PW'(D), lo_thr = 0;
  logic [31:0] isr_wd = 0, imr_wd = 0;
  logic [7:0] rd_data;
  logic [6:0] fsr;
  logic [PW-1:0] level;
  logic [31:0] isr;
  logic irq;

  pkt_fifo_ep #(.DEPTH(D), .DW(8)) u_pkt_fifo_ep (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wd),
    .pkt_commit_i(commit), .pkt_discard_i(discard),
    .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_retry_i(retry), .rd_ack_i(ack),
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .fsr_clr_i(fclr), .fsr_o(fsr), .level_o(level),
    .eof_i(eof), .eot_i(eot),
    .isr_wr_i(isr_wr), .isr_wdata_i(isr_wd), .isr_o(isr),
    .imr_wr_i(imr_wr), .imr_wdata_i(imr_wd), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int mw = 0, mwm = 0, mr = 0, mrm = 0;
  logic [7:0] mmem [D];
  bit movf = 0, mudf = 0;
  bit [4:0] mprev = '1;
  bit [31:0] misr = 0, mimr = 0;

  function automatic void check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic bit [6:0] exp_fsr();
    int lvl = mw - mr;
    return {mudf, movf, lvl < int'(lo_thr), lvl > int'(hi_thr),
            movf | mudf, (mw - mrm) == D, lvl == 0};
  endfunction

  // model of one clock edge, from the requirements
  function automatic void model_step();
    bit [6:0]  f = exp_fsr();
    bit [4:0]  c = {f[1], f[0], f[2], f[3], f[4]};
    bit [31:0] set = 0;
    bit full = f[1];
    bit hasd = (mr != mwm);
    for (int i = 0; i < 5; i++) set[4+i] = c[i] & ~mprev[i];
    set[2] = eot;
    set[0] = eof;
    mprev = c;
    misr = (misr & ~(isr_wr ? (isr_wd & WM) : 32'h0)) | set;
    if (imr_wr) mimr = imr_wd & WM;
    movf = (wr_en && !discard && full) | (movf & !fclr);
    mudf = (rd_en && !retry && !hasd) | (mudf & !fclr);
    if (discard) mw = mwm;
    else begin
      if (wr_en && !full) begin
        mmem[mw % D] = wd;
        mw++;
      end
      if (commit) mwm = mw;
    end
    if (retry) mr = mrm;
    else begin
      if (rd_en && hasd) mr++;
      if (ack) mrm = mr;
    end
  endfunction

  task automatic compare();
    check("R2", "level", 32'(level), 32'(mw - mr));
    check("R9", "fsr", 32'(fsr), 32'(exp_fsr()));
    check("R10", "isr", isr, misr);
    check("R13", "irq", 32'(irq), 32'(|(misr & mimr)));
    if (mr != mwm) check("R2", "rd_data", 32'(rd_data), 32'(mmem[mr % D]));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    {wr_en, commit, discard, rd_en, retry, ack, fclr, eof, eot, isr_wr, imr_wr} = '0;
  endtask

  task automatic put(int n, bit do_commit);
    for (int i = 0; i < n; i++) begin
      wr_en = 1;
      wd = 8'($urandom);
      commit = do_commit && (i == n - 1);
      tick();
    end
  endtask

  task automatic get(int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      tick();
    end
  endtask

  task automatic clear_isr();
    isr_wr = 1;
    isr_wd = '1;
    tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", "isr", isr, 0);
    check("R1", "fsr", 32'(fsr), 32'h1);
    check("R1", "level", 32'(level), 0);
    check("R1", "irq", 32'(irq), 0);
    tick();
    check("R1", "isr idle", isr, 0);

    // R2 R6: committed data in order
    wr_en = 1; wd = 8'hA5; tick();
    wr_en = 1; wd = 8'h3C; commit = 1; tick();
    check("R6", "level", 32'(level), 2);
    check("R2", "first byte", 32'(rd_data), 32'hA5);
    rd_en = 1; tick();
    check("R2", "second byte", 32'(rd_data), 32'h3C);
    rd_en = 1; ack = 1; tick();
    check("R7", "level", 32'(level), 0);
    clear_isr();

    // R3 R5 R14: fill without commit, overflow, discard with write
    put(D, 0);
    check("R3", "full", 32'(fsr[1]), 1);
    wr_en = 1; wd = 8'h11; tick();
    check("R3", "ovf", 32'(fsr[5]), 1);
    check("R3", "level held", 32'(level), 32'(D));
    discard = 1; wr_en = 1; commit = 1; tick();
    check("R5", "level after discard", 32'(level), 0);
    check("R5", "full gone", 32'(fsr[1]), 0);
    tick();
    check("R14", "full latched", 32'(isr[8]), 1);

    // R8: clear, and error wins over clear
    fclr = 1; tick();
    check("R8", "err cleared", 32'(fsr[2]), 0);
    rd_en = 1; fclr = 1; tick();
    check("R4", "udf on empty", 32'(fsr[6]), 1);
    check("R8", "err wins clear", 32'(fsr[2]), 1);
    fclr = 1; tick();
    // R4: uncommitted bytes unreadable
    put(2, 0);
    rd_en = 1; tick();
    check("R4", "level unchanged", 32'(level), 2);
    check("R4", "udf set", 32'(fsr[6]), 1);
    discard = 1; fclr = 1; tick();

    // R7 R14: single packet read then retried
    put(4, 1);
    b0 = rd_data;
    clear_isr();
    get(4);
    check("R7", "empty after read", 32'(fsr[0]), 1);
    retry = 1; rd_en = 1; tick();
    check("R7", "retry level", 32'(level), 4);
    check("R7", "retry data", 32'(rd_data), 32'(b0));
    tick();
    check("R14", "empty latched", 32'(isr[7]), 1);
    check("R14", "empty not live", 32'(fsr[0]), 0);
    get(4);
    ack = 1; tick();
    retry = 1; tick();
    check("R7", "ack holds", 32'(level), 0);

    // R9: thresholds
    clear_isr();
    hi_thr = 2; lo_thr = 2;
    tick();
    check("R9", "lo live", 32'(fsr[4]), 1);
    put(3, 1);
    check("R9", "hi live", 32'(fsr[3]), 1);
    tick();
    check("R10", "hi latched", 32'(isr[5]), 1);
    get(2);
    check("R9", "lo again", 32'(fsr[4]), 1);
    tick();
    check("R10", "lo latched", 32'(isr[4]), 1);
    hi_thr = PW'(D); lo_thr = 0;
    get(1); ack = 1; tick();

    // R11 R12 R13
    clear_isr();
    eof = 1; eot = 1; tick();
    check("R12", "eof eot", isr, 32'h5);
    imr_wr = 1; imr_wd = 32'hFFFF_FFFF; tick();
    check("R13", "irq on", 32'(irq), 1);
    isr_wr = 1; isr_wd = 32'h4; tick();
    check("R11", "w1c bit2 only", isr, 32'h1);
    isr_wr = 1; isr_wd = 32'h1; eof = 1; tick();
    check("R11", "event wins", isr, 32'h1);
    imr_wr = 1; imr_wd = 32'h4; tick();
    check("R13", "irq masked", 32'(irq), 0);
    isr_wr = 1; isr_wd = 32'h0; tick();
    check("R11", "zero write keeps", isr, 32'h1);
    check("R10", "reserved zero", isr & ~WM, 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      wr_en   = ($urandom % 100) < 50;
      wd      = 8'($urandom);
      commit  = ($urandom % 100) < 12;
      discard = ($urandom % 100) < 3;
      rd_en   = ($urandom % 100) < 40;
      retry   = ($urandom % 100) < 3;
      ack     = ($urandom % 100) < 12;
      fclr    = ($urandom % 100) < 3;
      eof     = ($urandom % 100) < 2;
      eot     = ($urandom % 100) < 2;
      isr_wr  = ($urandom % 100) < 6;
      isr_wd  = $urandom;
      imr_wr  = ($urandom % 100) < 2;
      imr_wd  = $urandom;
      if (($urandom % 100) < 2) begin
        hi_thr = PW'($urandom % (D + 1));
        lo_thr = PW'($urandom % (D + 1));
      end
      tick();
    end
    finish_run();
  end
endmodule